// File: doc/BRIEF.md
# Fixed-Rate Serial Master Shifter

This block is a single-master, byte-wide serial engine for talking to simple peripherals. It drives three lines: a serial clock, an outgoing data line and an enable strobe. The bit rate is fixed. It is set at elaboration by dividing the system clock, and software cannot change it. Incoming serial data arrives on a separate input. The CPU sees one data register. Writing it while the engine is idle starts a transfer. A busy flag reports that a transfer is running, and while it is set the register ignores every CPU read and write.

Each transfer moves eight bits, most significant first. After a write, the clock stays high for one half-bit interval and then produces eight low pulses. Outgoing data moves to the next bit on each falling edge of the clock after the first one. Incoming data is captured on each rising edge. When the eighth bit has been captured, busy drops and the data register holds the received byte. A mode input can hand all three lines to software-driven values instead, for general-purpose use.

Top module: `ser_shift_master`

## Requirements
- R1: While reset is applied and after it is released, busy is 0, rd_data is 0, and in shifter mode sck_o is 1 and sen_o is 0.
- R2: A write (wr_en=1) in shifter mode (mode_hw=1) while busy is 0 makes busy and sen_o 1 after that clock edge, and sdo_o shows wr_data bit 7.
- R3: After a start, sck_o stays high for HALF_DIV cycles. It then alternates low and high, HALF_DIV cycles each, for eight low pulses, and it is 1 whenever no transfer runs.
- R4: sdo_o presents the written byte most significant bit first, and it changes only on the second and later falling edges of sck_o.
- R5: sdi_i is captured on each rising edge of sck_o. After the transfer, a read returns the eight captured bits, with the first captured bit in bit 7.
- R6: busy and sen_o stay 1 for exactly 17*HALF_DIV cycles after the start edge, then fall together.
- R7: A write while busy is 1 has no effect: the running transfer, its duration and its received byte are unchanged.
- R8: A read (rd_en=1) while busy is 0 loads rd_data with the data register on the next edge. A read while busy is 1 leaves rd_data unchanged.
- R9: With mode_hw=0, sck_o, sdo_o and sen_o follow sw_sck, sw_sdo and sw_sen, and a write does not start a transfer.
- R10: HALF_DIV equals SYS_HZ / (2*BIT_HZ).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_hw | input | 1 | 1: shifter drives the pins, 0: software values drive them |
| sw_sck | input | 1 | Software value for the clock pin |
| sw_sdo | input | 1 | Software value for the data pin |
| sw_sen | input | 1 | Software value for the enable pin |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | DATA_W | Registered read result |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock pin |
| sdo_o | output | 1 | Serial data out pin |
| sen_o | output | 1 | Serial enable pin, active high |
| sdi_i | input | 1 | Serial data in |

## Verification
The bench builds the block with SYS_HZ=1,000,000 and BIT_HZ=125,000, which gives a half-bit of four system clocks. A whole transfer therefore takes 68 cycles, so many transfers fit in one short run. With a half-bit longer than one cycle, the checks can tell a shift on the wrong clock edge from a shift on the right one, and a late busy clear from an early one, which a divide of one would hide. At this size, mid-transfer writes and reads can be placed deep inside a transfer, and back-to-back transfers can follow each other directly.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int PIN_N   = 3;
  localparam int PIN_SCK = 0;
  localparam int PIN_SDO = 1;
  localparam int PIN_SEN = 2;

  function automatic int half_div(input int sys_hz, input int bit_hz);
    int d;
    d = sys_hz / (2 * bit_hz);
    return (d < 1) ? 1 : d;
  endfunction
endpackage

// File: rtl/ssm_clkdiv.sv
module ssm_clkdiv #(
  parameter int HALF_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF_DIV - 1));
  assign tick   = run && at_end;

  always_comb begin
    if (!run || at_end) cnt_d = '0;
    else                cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic sck,
  output logic sen,
  output logic sample_en,
  output logic shift_en
);
  localparam int LAST = 2 * DATA_W + 1;
  localparam int SW   = $clog2(LAST + 1);

  logic [SW-1:0] step_q, step_d, step_nx;
  logic          busy_d, sck_d;

  assign step_nx = step_q + SW'(1);
  assign sen     = busy;

  always_comb begin
    step_d    = step_q;
    busy_d    = busy;
    sck_d     = sck;
    sample_en = 1'b0;
    shift_en  = 1'b0;
    if (!busy) begin
      if (start) begin
        busy_d = 1'b1;
        step_d = '0;
        sck_d  = 1'b1;
      end
    end else if (tick) begin
      step_d = step_nx;
      if (step_nx == SW'(LAST)) begin
        busy_d   = 1'b0;
        sck_d    = 1'b1;
        shift_en = 1'b1;
      end else if (step_nx[0]) begin
        sck_d    = 1'b0;
        shift_en = (step_nx >= SW'(3));
      end else begin
        sck_d     = 1'b1;
        sample_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      busy   <= 1'b0;
      sck    <= 1'b1;
    end else begin
      step_q <= step_d;
      busy   <= busy_d;
      sck    <= sck_d;
    end
  end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sample_en,
  input  logic              shift_en,
  input  logic              sdi,
  output logic [DATA_W-1:0] data_q,
  output logic              sdo
);
  logic [DATA_W-1:0] data_d;
  logic              samp_q, samp_d;

  assign sdo = data_q[DATA_W-1];

  always_comb begin
    samp_d = sample_en ? sdi : samp_q;
    if (load)          data_d = load_data;
    else if (shift_en) data_d = {data_q[DATA_W-2:0], samp_q};
    else               data_d = data_q;
  end

  always_ff @(posedge clk) begin
    data_q <= data_d;
    samp_q <= samp_d;
  end
endmodule

// File: rtl/ser_shift_master.sv
module ser_shift_master #(
  parameter int DATA_W = 8,
  parameter int SYS_HZ = 16_000_000,
  parameter int BIT_HZ = 62_500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_hw,
  input  logic              sw_sck,
  input  logic              sw_sdo,
  input  logic              sw_sen,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              sen_o,
  input  logic              sdi_i
);
  import ssm_pkg::*;

  localparam int HALF_DIV = half_div(SYS_HZ, BIT_HZ);

  logic [1:0]        rsync_q;
  logic              rst_n_s;
  logic              start, tick, sample_en, shift_en;
  logic              hw_sck, hw_sen, hw_sdo;
  logic [DATA_W-1:0] data_q, rd_d;
  logic [PIN_N-1:0]  hw_pin, sw_pin, pin_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  assign start = wr_en && !busy && mode_hw;

  ssm_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n_s), .run(busy), .tick(tick)
  );

  ssm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start), .tick(tick),
    .busy(busy), .sck(hw_sck), .sen(hw_sen),
    .sample_en(sample_en), .shift_en(shift_en)
  );

  ssm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .load(start), .load_data(wr_data),
    .sample_en(sample_en), .shift_en(shift_en), .sdi(sdi_i),
    .data_q(data_q), .sdo(hw_sdo)
  );

  always_comb begin
    rd_d = (rd_en && !busy) ? data_q : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rd_data <= '0;
    else          rd_data <= rd_d;
  end

  assign hw_pin[PIN_SCK] = hw_sck;
  assign hw_pin[PIN_SDO] = hw_sdo;
  assign hw_pin[PIN_SEN] = hw_sen;
  assign sw_pin[PIN_SCK] = sw_sck;
  assign sw_pin[PIN_SDO] = sw_sdo;
  assign sw_pin[PIN_SEN] = sw_sen;

  for (genvar g = 0; g < PIN_N; g++) begin : g_pin
    assign pin_o[g] = mode_hw ? hw_pin[g] : sw_pin[g];
  end

  assign sck_o = pin_o[PIN_SCK];
  assign sdo_o = pin_o[PIN_SDO];
  assign sen_o = pin_o[PIN_SEN];
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_hw,
  input logic              wr_en,
  input logic              rd_en,
  input logic              busy,
  input logic              sck_o,
  input logic              sdo_o,
  input logic              sen_o,
  input logic [DATA_W-1:0] rd_data
);
  p_idle_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hw && !busy) |-> (sck_o && !sen_o));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hw && wr_en && !busy) |=> (busy && sen_o));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> $stable(rd_data));

  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hw && $past(mode_hw) && busy && $past(busy) && sck_o && $past(sck_o))
      |-> $stable(sdo_o));

  p_sw_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hw && !busy && wr_en) |=> !busy);
endmodule

bind ser_shift_master ssm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .mode_hw(mode_hw), .wr_en(wr_en),
  .rd_en(rd_en), .busy(busy), .sck_o(sck_o), .sdo_o(sdo_o),
  .sen_o(sen_o), .rd_data(rd_data)
);

// File: tb/ser_shift_master_test.sv
module ser_shift_master_test;
  localparam int SYS = 1_000_000;
  localparam int BIT = 125_000;
  localparam int H   = SYS / (2 * BIT);

  logic       clk, rst_n, mode_hw, sw_sck, sw_sdo, sw_sen;
  logic       wr_en, rd_en, sdi_i;
  logic [7:0] wr_data, rd_data;
  logic       busy, sck_o, sdo_o, sen_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  bit       m_busy = 0;
  int       e = 0;
  logic [7:0] m_tx = 0, m_rx = 0, m_data = 0, m_rd = 0, next_rx = 0;

  ser_shift_master #(.DATA_W(8), .SYS_HZ(SYS), .BIT_HZ(BIT)) uut (
    .clk(clk), .rst_n(rst_n), .mode_hw(mode_hw), .sw_sck(sw_sck),
    .sw_sdo(sw_sdo), .sw_sen(sw_sen), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .sck_o(sck_o),
    .sdo_o(sdo_o), .sen_o(sen_o), .sdi_i(sdi_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit was_busy = m_busy;
    logic [7:0] d_before = m_data;
    if (m_busy) begin
      e++;
      if (e == 17 * H) begin
        m_busy = 0;
        m_data = m_rx;
      end
    end else if (wr_en && mode_hw) begin
      m_busy = 1;
      e = 0;
      m_tx = wr_data;
      m_rx = next_rx;
      m_data = wr_data;
    end
    if (rd_en && !was_busy) m_rd = d_before;
  endtask

  task automatic compare();
    int n = e / H;
    bit exp_sck = 1'b1;
    int shifts;
    chk(busy == m_busy, "R6 busy", int'(busy), int'(m_busy));
    if (mode_hw) begin
      if (m_busy && n > 0) exp_sck = (n % 2 == 0);
      chk(sck_o == exp_sck, "R3 sck", int'(sck_o), int'(exp_sck));
      chk(sen_o == m_busy, "R2 enable", int'(sen_o), int'(m_busy));
      if (m_busy) begin
        shifts = (n >= 3) ? (n - 1) / 2 : 0;
        if (shifts > 7) shifts = 7;
        chk(sdo_o == m_tx[7-shifts], "R4 sdo", int'(sdo_o), int'(m_tx[7-shifts]));
      end
    end else begin
      chk({sck_o, sdo_o, sen_o} == {sw_sck, sw_sdo, sw_sen}, "R9 pins",
          int'({sck_o, sdo_o, sen_o}), int'({sw_sck, sw_sdo, sw_sen}));
    end
    chk(rd_data == m_rd, "R8 rd_data", int'(rd_data), int'(m_rd));
  endtask

  task automatic drive_sdi();
    int r;
    if (m_busy) begin
      r = (e / H) / 2;
      if (r < 8) sdi_i = m_rx[7-r];
      else       sdi_i = ~sdi_i;
    end else begin
      sdi_i = ~sdi_i;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    drive_sdi();
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input bit poke);
    int cnt = 0;
    logic [7:0] held;
    next_rx = rx;
    wr_data = tx;
    wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
    chk(busy && sen_o && sdo_o == tx[7], "R2 start", int'({busy, sen_o, sdo_o}),
        int'({2'b11, tx[7]}));
    while (busy && cnt < 1000) begin
      if (poke && cnt == 20) begin
        held = rd_data;
        wr_en = 1'b1;
        wr_data = ~tx;
        rd_en = 1'b1;
        cyc();
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk(rd_data == held, "R8 read while busy", int'(rd_data), int'(held));
      end else begin
        cyc();
      end
      cnt++;
    end
    chk(cnt == 17 * H, poke ? "R7 R10 duration" : "R10 duration", cnt, 17 * H);
    rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
    chk(rd_data == rx, poke ? "R7 R5 received" : "R5 received", int'(rd_data), int'(rx));
  endtask

  initial begin
    rst_n = 1'b0; mode_hw = 1'b1; sw_sck = 1'b0; sw_sdo = 1'b0; sw_sen = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00; sdi_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rd_data == 8'h00, "R1 reset state", int'({busy, rd_data}), 0);
    chk(sck_o == 1'b1 && sen_o == 1'b0, "R1 reset pins", int'({sck_o, sen_o}), 2);
    rst_n = 1'b1;
    repeat (5) cyc();
    chk(busy == 1'b0 && sck_o == 1'b1 && sen_o == 1'b0, "R1 after release",
        int'({busy, sck_o, sen_o}), 2);

    xfer(8'hA5, 8'h3C, 1'b0);
    xfer(8'h81, 8'hFF, 1'b1);
    repeat (3) cyc();

    mode_hw = 1'b0;
    for (int p = 0; p < 8; p++) begin
      {sw_sck, sw_sdo, sw_sen} = 3'(p);
      #1;
      chk({sck_o, sdo_o, sen_o} == 3'(p), "R9 software pins", int'({sck_o, sdo_o, sen_o}), p);
      cyc();
    end
    wr_data = 8'h5A;
    wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
    chk(busy == 1'b0, "R9 write ignored", int'(busy), 0);
    repeat (2) cyc();
    mode_hw = 1'b1;
    cyc();

    xfer(8'h00, 8'h00, 1'b0);
    xfer(8'h7E, 8'h81, 1'b0);
    xfer(8'hFF, 8'h6B, 1'b1);
    repeat (4) cyc();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule